// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Unit

This block holds a small bank of one-bit ownership flags that two independent ports, left and right, use to agree on which side may touch a shared resource. Each port requests a flag by writing 0 to it and releases it by writing 1. A read returns the flag as that port sees it: the owner reads 0 and the other side reads 1.

A request from the side that does not own a flag is not lost. It is remembered as pending. When the owner releases, ownership passes straight to the waiting side without another write. If both ports request the same free flag in the same clock cycle, the left port always wins and the right request becomes pending. Both ports share one clock. A synchronous reset frees every flag. Software should still release every flag from both ports at start-up, as it would on a part without reset.

Each port has an active-low semaphore select, a separate active-low memory enable, a write strobe, an output enable, an address bus and a write-data bus. An access counts only when the select is low and the memory enable is high. The low address bits pick the flag. Reads are registered and held until that port's next read.

Top module: `sema_unit`

## Requirements
- R1: While reset is high, every flag becomes free with no pending request. Both read buses go to all ones and both read-valid outputs go low.
- R2: The flag index is address bits [2:0] (log2 of the flag count). All higher address bits have no effect on which flag is touched.
- R3: A port accesses a flag only when its select is low (0) and its memory enable is high (1). In any other cycle its strobes have no effect on any flag and do not start a read.
- R4: A write (select low, enable high, write strobe low) uses only data bit 0. A 0 requests the flag and a 1 releases it. All other data bits are ignored.
- R5: A request to a free flag gives that port ownership. That port then reads all zeros and the other port reads all ones.
- R6: A request from the non-owner does not change ownership, and that port keeps reading ones. The request is held as pending.
- R7: When the owner releases a flag with no pending request, the flag becomes free and both ports read ones.
- R8: When the owner releases a flag while the other port's request is pending, or while the other port requests it in the same cycle, the other port owns the flag from the next clock edge.
- R9: When both ports request the same free flag in one cycle, the left port owns it and the right port's request becomes pending.
- R10: A port with a pending request cancels it by writing 1 to that flag. A later release by the owner then leaves the flag free.
- R11: A read (select low, enable high, write strobe high, output enable low) places the flag bit, as that port sees it before the edge, on all data lines at the next edge and raises read-valid for one cycle. The read bus holds its value until that port's next read, whatever the other port does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous reset, active high |
| l_sel_n | input | 1 | Left semaphore select, active low |
| l_mem_en_n | input | 1 | Left memory enable, must be high for a semaphore access |
| l_wr_n | input | 1 | Left write strobe, low = write |
| l_oe_n | input | 1 | Left output enable, low = read |
| l_addr | input | AW | Left address, low bits pick the flag |
| l_wdata | input | DW | Left write data, bit 0 used |
| l_rdata | output | DW | Left registered read data |
| l_rdata_vld | output | 1 | Left read data updated this cycle |
| r_sel_n | input | 1 | Right semaphore select, active low |
| r_mem_en_n | input | 1 | Right memory enable, must be high for a semaphore access |
| r_wr_n | input | 1 | Right write strobe, low = write |
| r_oe_n | input | 1 | Right output enable, low = read |
| r_addr | input | AW | Right address, low bits pick the flag |
| r_wdata | input | DW | Right write data, bit 0 used |
| r_rdata | output | DW | Right registered read data |
| r_rdata_vld | output | 1 | Right read data updated this cycle |

## Verification
The bench builds the unit with eight flags, a 6-bit address and 8-bit data. With these sizes every address value can be swept, which shows that the upper bits are ignored. Every flag also runs through the full request, deny, hand-over, tie and cancel sequence from both sides. A long random phase then drives both ports at once, with select, enable, strobes, address and data all random. Each cycle's read results are compared with a reference model written from the requirements. This brings same-cycle collisions, releases that meet requests, and cancels into play on every flag.

// File: rtl/sema_unit.sv
module sema_unit #(
  parameter int NUM_FLAGS = 8,
  parameter int AW = 14,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          l_sel_n,
  input  logic          l_mem_en_n,
  input  logic          l_wr_n,
  input  logic          l_oe_n,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          l_rdata_vld,
  input  logic          r_sel_n,
  input  logic          r_mem_en_n,
  input  logic          r_wr_n,
  input  logic          r_oe_n,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  output logic          r_rdata_vld
);

  localparam int IW = (NUM_FLAGS > 1) ? $clog2(NUM_FLAGS) : 1;
  localparam logic [1:0] OWN_FREE = 2'd0;
  localparam logic [1:0] OWN_L    = 2'd1;
  localparam logic [1:0] OWN_R    = 2'd2;

  logic [NUM_FLAGS-1:0][1:0] own, own_nx;
  logic [NUM_FLAGS-1:0]      pend_l, pend_r, pend_l_nx, pend_r_nx;

  logic l_acc, l_wr, l_rd, r_acc, r_wr, r_rd;
  logic [IW-1:0] l_idx, r_idx;
  logic l_bit, r_bit;

  assign l_acc = !l_sel_n && l_mem_en_n;
  assign r_acc = !r_sel_n && r_mem_en_n;
  assign l_wr  = l_acc && !l_wr_n;
  assign r_wr  = r_acc && !r_wr_n;
  assign l_rd  = l_acc && l_wr_n && !l_oe_n;
  assign r_rd  = r_acc && r_wr_n && !r_oe_n;
  assign l_idx = l_addr[IW-1:0];
  assign r_idx = r_addr[IW-1:0];

  logic unused_bits;
  assign unused_bits = ^{l_addr[AW-1:IW], r_addr[AW-1:IW], l_wdata[DW-1:1], r_wdata[DW-1:1]};

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    logic lw, lq, lr, rw, rq, rr;
    logic [1:0] o_n;
    logic pl_n, pr_n;

    assign lw = l_wr && (l_idx == IW'(g));
    assign rw = r_wr && (r_idx == IW'(g));
    assign lq = lw && !l_wdata[0];
    assign lr = lw && l_wdata[0];
    assign rq = rw && !r_wdata[0];
    assign rr = rw && r_wdata[0];

    always_comb begin
      o_n  = own[g];
      pl_n = pend_l[g];
      pr_n = pend_r[g];
      case (own[g])
        OWN_L: begin
          if (lr) begin
            o_n  = (rq || (pend_r[g] && !rr)) ? OWN_R : OWN_FREE;
            pr_n = 1'b0;
          end else if (rq) begin
            pr_n = 1'b1;
          end else if (rr) begin
            pr_n = 1'b0;
          end
        end
        OWN_R: begin
          if (rr) begin
            o_n  = (lq || (pend_l[g] && !lr)) ? OWN_L : OWN_FREE;
            pl_n = 1'b0;
          end else if (lq) begin
            pl_n = 1'b1;
          end else if (lr) begin
            pl_n = 1'b0;
          end
        end
        default: begin
          pl_n = 1'b0;
          pr_n = rq && lq;
          if (lq)      o_n = OWN_L;
          else if (rq) o_n = OWN_R;
          else         o_n = OWN_FREE;
        end
      endcase
    end

    assign own_nx[g]    = o_n;
    assign pend_l_nx[g] = pl_n;
    assign pend_r_nx[g] = pr_n;

    AST_FREE_NO_PEND: assert property (@(posedge clk) disable iff (rst)
      (own[g] == OWN_FREE) |-> !(pend_l[g] || pend_r[g])); // R7
    AST_NONOWNER_DENIED: assert property (@(posedge clk) disable iff (rst)
      (own[g] == OWN_L && !lw) |=> (own[g] == OWN_L)); // R6
    AST_HANDOVER: assert property (@(posedge clk) disable iff (rst)
      (own[g] == OWN_L && pend_r[g] && lr && !rr) |=> (own[g] == OWN_R)); // R8
    AST_TIE_LEFT: assert property (@(posedge clk) disable iff (rst)
      (own[g] == OWN_FREE && lq && rq) |=> (own[g] == OWN_L && pend_r[g])); // R9
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own    <= '0;
      pend_l <= '0;
      pend_r <= '0;
    end else begin
      own    <= own_nx;
      pend_l <= pend_l_nx;
      pend_r <= pend_r_nx;
    end
  end

  assign l_bit = (own[l_idx] != OWN_L);
  assign r_bit = (own[r_idx] != OWN_R);

  always_ff @(posedge clk) begin
    if (rst) begin
      l_rdata     <= '1;
      r_rdata     <= '1;
      l_rdata_vld <= 1'b0;
      r_rdata_vld <= 1'b0;
    end else begin
      l_rdata_vld <= l_rd;
      r_rdata_vld <= r_rd;
      if (l_rd) l_rdata <= {DW{l_bit}};
      if (r_rd) r_rdata <= {DW{r_bit}};
    end
  end

  AST_L_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
    !l_rd |=> $stable(l_rdata)); // R11
  AST_R_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
    !r_rd |=> $stable(r_rdata)); // R11
  AST_SINGLE_OWNER_READ: assert property (@(posedge clk) disable iff (rst)
    (l_rd && r_rd && l_idx == r_idx) |=> (l_rdata[0] || r_rdata[0])); // R5

endmodule

// File: tb/sim_sema_unit.sv
module sim_sema_unit;
  localparam int NF = 8;
  localparam int AW = 6;
  localparam int DW = 8;

  logic clk = 0, rst = 1;
  logic l_sel_n, l_mem_en_n, l_wr_n, l_oe_n, r_sel_n, r_mem_en_n, r_wr_n, r_oe_n;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic l_rdata_vld, r_rdata_vld;

  int n_chk = 0, n_bad = 0;
  int mown [NF];
  bit mpl [NF], mpr [NF];
  logic [DW-1:0] exp_l = '1, exp_r = '1;
  logic exp_lv = 0, exp_rv = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sema_unit #(.NUM_FLAGS(NF), .AW(AW), .DW(DW)) u0 (
    .clk, .rst,
    .l_sel_n, .l_mem_en_n, .l_wr_n, .l_oe_n, .l_addr, .l_wdata, .l_rdata, .l_rdata_vld,
    .r_sel_n, .r_mem_en_n, .r_wr_n, .r_oe_n, .r_addr, .r_wdata, .r_rdata, .r_rdata_vld);

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    l_sel_n = 1; l_mem_en_n = 1; l_wr_n = 1; l_oe_n = 1; l_addr = '0; l_wdata = '1;
    r_sel_n = 1; r_mem_en_n = 1; r_wr_n = 1; r_oe_n = 1; r_addr = '0; r_wdata = '1;
  endtask

  function automatic logic [AW-1:0] adr(input int f);
    return AW'(f) | (AW'($urandom) & ~AW'(NF - 1));
  endfunction

  task automatic lw(input int f, input bit b);
    l_sel_n = 0; l_mem_en_n = 1; l_wr_n = 0; l_oe_n = 1; l_addr = adr(f);
    l_wdata = {DW{~b}} ^ DW'(1) ^ {{(DW-1){1'b0}}, ~b} ^ DW'(1);
    l_wdata[0] = b;
  endtask
  task automatic rw(input int f, input bit b);
    r_sel_n = 0; r_mem_en_n = 1; r_wr_n = 0; r_oe_n = 1; r_addr = adr(f);
    r_wdata = DW'($urandom); r_wdata[0] = b;
  endtask
  task automatic lr(input int f);
    l_sel_n = 0; l_mem_en_n = 1; l_wr_n = 1; l_oe_n = 0; l_addr = adr(f);
  endtask
  task automatic rr(input int f);
    r_sel_n = 0; r_mem_en_n = 1; r_wr_n = 1; r_oe_n = 0; r_addr = adr(f);
  endtask

  // Reference model from R3..R11, applied at the edge; outputs compared every cycle.
  task automatic tick(input string tag);
    bit la, ra, lwe, rwe, lrd, rrd;
    int li, ri;
    la = !l_sel_n && l_mem_en_n; ra = !r_sel_n && r_mem_en_n;
    lwe = la && !l_wr_n; rwe = ra && !r_wr_n;
    lrd = la && l_wr_n && !l_oe_n; rrd = ra && r_wr_n && !r_oe_n;
    li = int'(l_addr) % NF; ri = int'(r_addr) % NF;
    @(posedge clk);
    if (rst) begin
      foreach (mown[f]) begin mown[f] = 0; mpl[f] = 0; mpr[f] = 0; end
      exp_l = '1; exp_r = '1; exp_lv = 0; exp_rv = 0;
    end else begin
      exp_lv = lrd; exp_rv = rrd;
      if (lrd) exp_l = (mown[li] == 1) ? '0 : '1;
      if (rrd) exp_r = (mown[ri] == 2) ? '0 : '1;
      for (int f = 0; f < NF; f++) begin
        bit lq, lre, rq, rre;
        lq = lwe && li == f && !l_wdata[0]; lre = lwe && li == f && l_wdata[0];
        rq = rwe && ri == f && !r_wdata[0]; rre = rwe && ri == f && r_wdata[0];
        if (mown[f] == 0) begin
          if (lq) begin mown[f] = 1; mpr[f] = rq; end
          else if (rq) mown[f] = 2;
        end else if (mown[f] == 1) begin
          if (lre) begin
            mown[f] = (rq || (mpr[f] && !rre)) ? 2 : 0; mpr[f] = 0;
          end else if (rq) mpr[f] = 1;
          else if (rre) mpr[f] = 0;
        end else begin
          if (rre) begin
            mown[f] = (lq || (mpl[f] && !lre)) ? 1 : 0; mpl[f] = 0;
          end else if (lq) mpl[f] = 1;
          else if (lre) mpl[f] = 0;
        end
      end
    end
    @(negedge clk);
    chk(l_rdata == exp_l && l_rdata_vld == exp_lv, {tag, " left R11"}, l_rdata, exp_l);
    chk(r_rdata == exp_r && r_rdata_vld == exp_rv, {tag, " right R11"}, r_rdata, exp_r);
  endtask

  task automatic readboth(input int f, input string tag, input logic [DW-1:0] el, input logic [DW-1:0] er);
    idle(); lr(f); rr(f); tick(tag);
    chk(l_rdata == el, {tag, " left"}, l_rdata, el);
    chk(r_rdata == er, {tag, " right"}, r_rdata, er);
    idle();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    @(negedge clk);
    tick("R1 reset"); tick("R1 reset");
    chk(l_rdata == '1 && !l_rdata_vld, "R1 left", l_rdata, '1);
    chk(r_rdata == '1 && !r_rdata_vld, "R1 right", r_rdata, '1);
    rst = 0;
    idle(); tick("R1 idle");

    for (int f = 0; f < NF; f++) begin
      idle(); lw(f, 0); tick("R5 req");
      readboth(f, "R5", '0, '1);
      rw(f, 0); tick("R6 deny");
      readboth(f, "R6", '0, '1);
      lw(f, 1); tick("R8 release");
      readboth(f, "R8", '1, '0);
      rw(f, 1); tick("R7 release");
      readboth(f, "R7", '1, '1);
      lw(f, 0); rw(f, 0); tick("R9 tie");
      readboth(f, "R9", '0, '1);
      lw(f, 1); tick("R9 handover");
      readboth(f, "R9 pend", '1, '0);
      rw(f, 1); tick("R9 clear");
      idle(); rw(f, 0); tick("R10 req");
      lw(f, 0); tick("R10 pend");
      lw(f, 1); tick("R10 cancel");
      rw(f, 1); tick("R10 release");
      readboth(f, "R10", '1, '1);
      lw(f, 0); l_mem_en_n = 0; tick("R3 enable low");
      idle(); lw(f, 0); l_sel_n = 1; tick("R3 select high");
      idle(); lr(f); l_mem_en_n = 0; rr(f); tick("R3 read blocked");
      chk(!l_rdata_vld, "R3 no read", {7'b0, l_rdata_vld}, '0);
      readboth(f, "R3", '1, '1);
      lw(f, 0); l_wdata = 8'hFE; tick("R4 request");
      readboth(f, "R4 req", '0, '1);
      lw(f, 1); l_wdata = 8'h01; tick("R4 release");
      readboth(f, "R4 rel", '1, '1);
    end

    for (int a = 0; a < (1 << AW); a++) begin
      idle(); rw(0, 0); r_addr = AW'(a); tick("R2 req");
      idle(); rr(a % NF); lr(a % NF); tick("R2 read");
      chk(r_rdata == '0, "R2 owner", r_rdata, '0);
      chk(l_rdata == '1, "R2 other", l_rdata, '1);
      idle(); rw(0, 1); r_addr = AW'(a); tick("R2 rel");
    end

    idle(); lw(3, 0); tick("R11 take");
    idle(); rr(3); tick("R11 read");
    idle(); lw(3, 1); tick("R11 release");
    idle(); tick("R11 hold");
    chk(r_rdata == '1 && !r_rdata_vld, "R11 held", r_rdata, '1);

    for (int c = 0; c < 6000; c++) begin
      logic [31:0] x;
      x = $urandom;
      l_sel_n = x[0] & x[1]; l_mem_en_n = x[2] | x[3]; l_wr_n = x[4]; l_oe_n = x[5] & x[6];
      l_addr = AW'(x[13:8]); l_wdata = DW'(x[23:16]);
      x = $urandom;
      r_sel_n = x[0] & x[1]; r_mem_en_n = x[2] | x[3]; r_wr_n = x[4]; r_oe_n = x[5] & x[6];
      r_addr = AW'(x[13:8]); r_wdata = DW'(x[23:16]);
      tick("R8 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule